// File: doc/BRIEF.md
# Serial Slave Memory Bridge

This block lets an external SPI host read and write a byte-addressed memory space of 2^ADDR_W locations (64K by default). Each transaction opens when the active-low select falls. It carries an 8-bit command, then a 16-bit address, then any number of data bytes, all shifted most-significant bit first. The top two command bits choose the kind of access. `11` streams memory bytes out on the serial output. `10` stores incoming bytes into memory. Any command with the top bit clear is a mailbox command: its command byte and address are latched for the local processor and its data bytes are dropped. The address steps by one after every data byte, for as long as select stays low.

The pins run in SPI mode 0. Input is sampled on the rising serial clock and output changes on the falling edge. Select, clock and data-in are synchronised into the system clock, which must run at least 8 times faster than the serial clock. Memory is reached through a request channel (valid/ready) and a response strobe. A request stays presented, with unchanged fields, until the sink raises ready. Only one request is outstanding at a time. A read answer arrives as a one-cycle `mem_rsp_valid` some cycles after acceptance. Back-pressure is bounded: the first read of a burst must be accepted and answered within about three system clocks, and any later request has close to a full byte time. When select rises at the end of a transaction whose command asks for it, a single-cycle interrupt pulse is raised.

Top module: `spi_ram_bridge`

## Requirements
- R1: A frame is sent MSB first: serial clocks 0-7 carry the command, 8-23 the address, and 24 onward the data bytes.
- R2: A command with bits [7:6] = `11` drives memory bytes on `spi_miso`, MSB first. The first byte comes from the received address and is valid before the rising edge of clock 24.
- R3: A command with bits [7:6] = `10` issues one memory write (`mem_req_we`=1) for each complete data byte received, holding that byte.
- R4: Within a read or write burst, the address rises by one per data byte and wraps from 0xFFFF to 0x0000.
- R5: `spi_miso_oe` is low during the command and address of every frame, and throughout write and mailbox frames. It is high only in the data phase of a read.
- R6: `irq_pulse` is high for exactly one system clock after select rises, for every completed-header frame except the commands 0xC0 and 0x80, which raise no pulse.
- R7: A command with bit 7 = 0 loads `mbox_cmd` and `mbox_addr` once the address is complete. Its data bytes cause no memory request.
- R8: A frame ended before its 24th address clock causes no interrupt, no memory write and no mailbox update.
- R9: A data byte cut short by select rising is discarded and is not written.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address, data and direction are held unchanged.
- R11: After reset, `irq_pulse`, `spi_miso_oe` and `mem_req_valid` are low, and the mailbox outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low frame select from host |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the serial data pad (low = high impedance) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory sink accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address of the request |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | One-cycle strobe for a read answer |
| mem_rsp_rdata | input | 8 | Read answer byte |
| mbox_cmd | output | 8 | Last mailbox command byte |
| mbox_addr | output | ADDR_W | Last mailbox address |
| irq_pulse | output | 1 | One-cycle processor interrupt |

## Verification
The hardest situations to reach from the pins are frames that end at awkward points. These are a select release mid-header or partway into a data byte, and an address walk across 0xFFFF while the memory sink is refusing requests. The bench drives its serial host bit by bit, with an explicit bit count at which select is released. A write burst is started at 0xFFFF while the memory model withholds ready three cycles in four. Every one of the 256 command codes is also swept with a header-only frame, so the class decode, the quiet codes and the mailbox capture are covered arithmetically.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DATA
  } phase_e;

  typedef enum logic [1:0] {
    CLS_MBOX,
    CLS_WRITE,
    CLS_READ
  } cmd_class_e;

  // Class comes from the two most significant command bits.
  function automatic cmd_class_e classify(input logic [1:0] top);
    if (!top[1]) return CLS_MBOX;
    return top[0] ? CLS_READ : CLS_WRITE;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_raw,
  input  logic cs_n_raw,
  input  logic mosi_raw,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic sel_start,
  output logic sel_end,
  output logic mosi_s
);
  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [2:0] RST_VAL = 3'b010; // {mosi, cs_n, sck}

  logic [2:0] stg [SYNC_STAGES];
  logic       sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= {mosi_raw, cs_n_raw, sck_raw};
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= stg[LAST][0];
      cs_d  <= stg[LAST][1];
    end
  end

  assign sck_rise  =  stg[LAST][0] & ~sck_d;
  assign sck_fall  = ~stg[LAST][0] &  sck_d;
  assign sel       = ~stg[LAST][1];
  assign sel_start = ~stg[LAST][1] &  cs_d;
  assign sel_end   =  stg[LAST][1] & ~cs_d;
  assign mosi_s    =  stg[LAST][2];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CMD_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sel,
  input  logic              sel_start,
  input  logic              sel_end,
  input  logic              mosi_s,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              miso_bit,
  output logic              miso_oe,
  output logic              rd_req,
  output logic              wr_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              irq,
  output logic [CMD_W-1:0]  mbox_cmd,
  output logic [ADDR_W-1:0] mbox_addr
);
  localparam int SH_W  = (ADDR_W > CMD_W) ? ADDR_W : CMD_W;
  localparam int CNT_W = $clog2(SH_W);
  localparam int DB_W  = $clog2(DATA_W);
  localparam logic [CMD_W-1:0] RD_QUIET = {2'b11, {(CMD_W-2){1'b0}}};
  localparam logic [CMD_W-1:0] WR_QUIET = {2'b10, {(CMD_W-2){1'b0}}};

  phase_e            phase;
  cmd_class_e        cls;
  logic [SH_W-1:0]   in_sh, sh_next;
  logic [CNT_W-1:0]  hdr_cnt;
  logic [DB_W-1:0]   dbit;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              addr_done;
  logic [DATA_W-1:0] out_sh, pref_q;
  logic              oe_q;
  logic              irq_wanted;

  assign sh_next    = {in_sh[SH_W-2:0], mosi_s};
  assign irq_wanted = (cls == CLS_MBOX) || ((cmd_q != RD_QUIET) && (cmd_q != WR_QUIET));
  assign miso_bit   = out_sh[DATA_W-1];
  assign miso_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cls       <= CLS_MBOX;
      in_sh     <= '0;
      hdr_cnt   <= '0;
      dbit      <= '0;
      cmd_q     <= '0;
      cur_addr  <= '0;
      addr_done <= 1'b0;
      out_sh    <= '0;
      pref_q    <= '0;
      oe_q      <= 1'b0;
      rd_req    <= 1'b0;
      wr_req    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      irq       <= 1'b0;
      mbox_cmd  <= '0;
      mbox_addr <= '0;
    end else begin
      rd_req <= 1'b0;
      wr_req <= 1'b0;
      irq    <= 1'b0;
      if (rsp_valid) pref_q <= rsp_data;

      if (sel_start) begin
        phase     <= PH_CMD;
        hdr_cnt   <= '0;
        dbit      <= '0;
        addr_done <= 1'b0;
        oe_q      <= 1'b0;
      end else if (sel_end) begin
        phase <= PH_IDLE;
        oe_q  <= 1'b0;
        irq   <= addr_done && irq_wanted;
      end else if (sel && sck_rise) begin
        in_sh <= sh_next;
        case (phase)
          PH_CMD: begin
            if (hdr_cnt == CNT_W'(CMD_W-1)) begin
              cmd_q   <= sh_next[CMD_W-1:0];
              cls     <= classify(sh_next[CMD_W-1 -: 2]);
              phase   <= PH_ADDR;
              hdr_cnt <= '0;
            end else begin
              hdr_cnt <= hdr_cnt + 1'b1;
            end
          end
          PH_ADDR: begin
            if (hdr_cnt == CNT_W'(ADDR_W-1)) begin
              cur_addr  <= sh_next[ADDR_W-1:0];
              req_addr  <= sh_next[ADDR_W-1:0];
              phase     <= PH_DATA;
              addr_done <= 1'b1;
              if (cls == CLS_READ) rd_req <= 1'b1;
              if (cls == CLS_MBOX) begin
                mbox_cmd  <= cmd_q;
                mbox_addr <= sh_next[ADDR_W-1:0];
              end
            end else begin
              hdr_cnt <= hdr_cnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (dbit == DB_W'(DATA_W-1)) begin
              dbit <= '0;
              if (cls == CLS_WRITE) begin
                wr_req    <= 1'b1;
                req_addr  <= cur_addr;
                req_wdata <= sh_next[DATA_W-1:0];
                cur_addr  <= cur_addr + 1'b1;
              end
            end else begin
              dbit <= dbit + 1'b1;
            end
          end
          default: ;
        endcase
      end else if (sel && sck_fall && phase == PH_DATA && cls == CLS_READ) begin
        if (dbit == '0) begin
          // byte boundary: present the prefetched byte, fetch the next one
          out_sh   <= pref_q;
          oe_q     <= 1'b1;
          rd_req   <= 1'b1;
          req_addr <= cur_addr + 1'b1;
          cur_addr <= cur_addr + 1'b1;
        end else begin
          out_sh <= {out_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assert_oe_read_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (phase == PH_DATA && cls == CLS_READ));

  assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_write_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (cls == CLS_WRITE && phase == PH_DATA));

  assert_req_after_header_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_req) |-> addr_done);

  assert_mbox_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_MBOX && phase == PH_DATA) |-> !wr_req && !rd_req);

endmodule

// File: rtl/spi_mem_port.sv
module spi_mem_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else if (rd_req || wr_req) begin
      mem_req_valid <= 1'b1;
      mem_req_we    <= wr_req;
      mem_req_addr  <= req_addr;
      mem_req_wdata <= wr_req ? req_wdata : '0;
    end else if (mem_req_ready) begin
      mem_req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && (rd_req || wr_req))
      assert_no_overrun_R10: assert (!mem_req_valid || mem_req_ready)
        else $error("request slot still occupied");
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

endmodule

// File: rtl/spi_ram_bridge.sv
module spi_ram_bridge #(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_rdata,
  output logic [7:0]        mbox_cmd,
  output logic [ADDR_W-1:0] mbox_addr,
  output logic              irq_pulse
);
  localparam int CMD_W  = 8;
  localparam int DATA_W = 8;

  logic sck_rise, sck_fall, sel, sel_start, sel_end, mosi_s;
  logic miso_bit, oe;
  logic rd_req, wr_req;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sck_raw(spi_sck), .cs_n_raw(spi_cs_n), .mosi_raw(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel),
    .sel_start(sel_start), .sel_end(sel_end), .mosi_s(mosi_s)
  );

  spi_frame_engine #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel),
    .sel_start(sel_start), .sel_end(sel_end), .mosi_s(mosi_s),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_rdata),
    .miso_bit(miso_bit), .miso_oe(oe),
    .rd_req(rd_req), .wr_req(wr_req), .req_addr(req_addr), .req_wdata(req_wdata),
    .irq(irq_pulse), .mbox_cmd(mbox_cmd), .mbox_addr(mbox_addr)
  );

  spi_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .wr_req(wr_req), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
  );

  assign spi_miso    = oe & miso_bit;
  assign spi_miso_oe = oe;

  assert_irq_outside_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> spi_cs_n);

endmodule

// File: tb/spi_ram_bridge_tb.sv
module spi_ram_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;   // system clocks per serial half period (16x ratio)
  localparam int LOG_D      = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic mem_req_valid, mem_req_ready = 1'b1, mem_req_we;
  logic [15:0] mem_req_addr, mbox_addr;
  logic [7:0] mem_req_wdata, mbox_cmd;
  logic mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_rdata = '0;
  logic irq_pulse;

  int errors = 0, checks = 0;
  int irq_cnt = 0, wlog_n = 0, stall_ctr = 0;
  bit stall_en = 0, done = 0;
  logic [15:0] wlog_addr [LOG_D];
  logic [7:0]  wlog_data [LOG_D];
  logic [7:0]  rd_bytes [8];
  logic rsp_pend = 0;
  logic [7:0] rsp_next = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ram_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mbox_cmd(mbox_cmd), .mbox_addr(mbox_addr), .irq_pulse(irq_pulse)
  );

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic int exp_irq(input logic [7:0] c);
    if (!c[7]) return 1;
    return (c == 8'hC0 || c == 8'h80) ? 0 : 1;
  endfunction

  // memory sink model: ready for the coming edge, then note what that edge accepts
  always @(negedge clk) begin
    mem_rsp_valid = rsp_pend;
    mem_rsp_rdata = rsp_next;
    rsp_pend = 1'b0;
    stall_ctr++;
    mem_req_ready = stall_en ? (stall_ctr[1:0] == 2'd3) : 1'b1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        if (wlog_n < LOG_D) begin
          wlog_addr[wlog_n] = mem_req_addr;
          wlog_data[wlog_n] = mem_req_wdata;
        end
        wlog_n++;
      end else begin
        rsp_pend = 1'b1;
        rsp_next = mem_val(mem_req_addr);
      end
    end
    if (irq_pulse) irq_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One host frame. stop_bits > 0 releases select after that many clocks.
  task automatic xfer(input logic [7:0] cmd, input logic [15:0] addr, input int nbytes,
                      input int tail_bits, input int stop_bits, input logic [7:0] wseed,
                      output int oe_bad);
    int total;
    oe_bad = 0;
    irq_cnt = 0;
    total = (stop_bits > 0) ? stop_bits : 24 + 8*nbytes + tail_bits;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < total; k++) begin
      logic b;
      if (k < 8)       b = cmd[7-k];
      else if (k < 24) b = addr[23-k];
      else begin
        logic [7:0] wb;
        wb = wseed + 8'((k-24)/8 * 17);
        b = wb[7-((k-24)%8)];
      end
      spi_mosi = b;
      repeat (HALF) @(negedge clk);
      if (k >= 24 && (k-24)/8 < 8) rd_bytes[(k-24)/8][7-((k-24)%8)] = spi_miso;
      if (spi_miso_oe !== ((k >= 24) && (cmd[7:6] == 2'b11))) oe_bad++;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ob;
    repeat (5) @(negedge clk);
    // R11: reset state
    chk(irq_pulse == 0 && spi_miso_oe == 0 && mem_req_valid == 0, "R11 outputs", {irq_pulse, spi_miso_oe, mem_req_valid}, 0);
    chk(mbox_cmd == 0 && mbox_addr == 0, "R11 mailbox", {mbox_cmd, mbox_addr}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Sweep every command code with a header-only frame (R1 decode, R5, R6, R7)
    for (int c = 0; c < 256; c++) begin
      logic [15:0] a;
      a = {8'(c) ^ 8'hA5, 8'(c)};
      xfer(8'(c), a, 0, 0, 0, 8'h00, ob);
      chk(irq_cnt == exp_irq(8'(c)), "R6 irq per command", irq_cnt, exp_irq(8'(c)));
      chk(ob == 0, "R5 oe low in header", ob, 0);
      if (c < 128) chk(mbox_cmd == 8'(c) && mbox_addr == a, "R7 mailbox capture", {mbox_cmd, mbox_addr}, {8'(c), a});
    end
    chk(wlog_n == 0, "R3 header-only write stores nothing", wlog_n, 0);

    // Mailbox frame with data bytes: captured, data ignored (R7)
    wlog_n = 0;
    xfer(8'h3C, 16'hBEEF, 2, 0, 0, 8'h61, ob);
    chk(mbox_cmd == 8'h3C && mbox_addr == 16'hBEEF, "R7 mailbox with data", {mbox_cmd, mbox_addr}, {8'h3C, 16'hBEEF});
    chk(wlog_n == 0, "R7 data ignored", wlog_n, 0);
    chk(irq_cnt == 1, "R7 irq", irq_cnt, 1);
    chk(ob == 0, "R5 oe mailbox", ob, 0);

    // Aborted headers (R8)
    xfer(8'h40, 16'h1357, 0, 0, 15, 8'h00, ob);
    chk(irq_cnt == 0, "R8 abort mailbox irq", irq_cnt, 0);
    chk(mbox_cmd == 8'h3C && mbox_addr == 16'hBEEF, "R8 mailbox unchanged", {mbox_cmd, mbox_addr}, {8'h3C, 16'hBEEF});
    xfer(8'h81, 16'h2468, 0, 0, 20, 8'h00, ob);
    chk(irq_cnt == 0 && wlog_n == 0, "R8 abort write", irq_cnt + wlog_n, 0);
    xfer(8'hC3, 16'h0F0F, 0, 0, 23, 8'h00, ob);
    chk(irq_cnt == 0, "R8 abort read irq", irq_cnt, 0);

    // Quiet write across wrap with back-pressure (R3, R4, R10, R6)
    stall_en = 1;
    xfer(8'h80, 16'hFFFF, 3, 0, 0, 8'hA0, ob);
    stall_en = 0;
    chk(wlog_n == 3, "R3 write count", wlog_n, 3);
    for (int i = 0; i < 3; i++) begin
      logic [15:0] ea;
      logic [7:0] ed;
      ea = 16'hFFFF + 16'(i);
      ed = 8'hA0 + 8'(i*17);
      chk(wlog_addr[i] == ea, "R4 write address wrap", wlog_addr[i], ea);
      chk(wlog_data[i] == ed, "R10 write data under stall", wlog_data[i], ed);
    end
    chk(irq_cnt == 0, "R6 quiet write", irq_cnt, 0);
    chk(ob == 0, "R5 oe write", ob, 0);

    // Write with trailing partial byte (R9)
    wlog_n = 0;
    xfer(8'h9A, 16'h0100, 2, 5, 0, 8'h10, ob);
    chk(wlog_n == 2, "R9 partial byte dropped", wlog_n, 2);
    chk(wlog_addr[1] == 16'h0101 && wlog_data[1] == 8'h21, "R3 second byte", {wlog_addr[1], wlog_data[1]}, {16'h0101, 8'h21});
    chk(irq_cnt == 1, "R6 write irq", irq_cnt, 1);

    // Quiet read across wrap (R2, R4, R6)
    xfer(8'hC0, 16'hFFFE, 4, 0, 0, 8'h00, ob);
    for (int i = 0; i < 4; i++)
      chk(rd_bytes[i] == mem_val(16'hFFFE + 16'(i)), "R2 read byte wrap", rd_bytes[i], mem_val(16'hFFFE + 16'(i)));
    chk(irq_cnt == 0, "R6 quiet read", irq_cnt, 0);
    chk(ob == 0, "R5 oe read data", ob, 0);

    // Long interrupting read (R1 MSB first, R2, R4)
    xfer(8'hD7, 16'h12F9, 8, 0, 0, 8'h00, ob);
    for (int i = 0; i < 8; i++)
      chk(rd_bytes[i] == mem_val(16'h12F9 + 16'(i)), "R1 read order", rd_bytes[i], mem_val(16'h12F9 + 16'(i)));
    chk(irq_cnt == 1, "R6 read irq", irq_cnt, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule